// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serializer at the core of an SPI master. It pulls words from a show-ahead transmit FIFO, which lives outside the block. It shifts each word out on `mosi` with the most significant bit first. At the same time it assembles the bits it samples on `miso` into a received word and hands that word to an external receive FIFO through a one-cycle push strobe. One word is always received for every word sent.

Static configuration inputs control the transfer:
- the word size: 8, 16 or 32 bits;
- the clock idle level;
- which clock edge launches data;
- whether `miso` is sampled in the middle or at the end of each bit time;
- a 9-bit divider that sets the serial clock to the input clock divided by 2×(divider+1).

An optional hardware slave-select output is held active while a word is in flight or waiting in the transmit FIFO. When the FIFO runs empty between words, the serial clock rests at its idle level. Clearing the enable stops a transfer in progress immediately.

Top module: `spi_shift_engine`

## Requirements
- R1: While a word is shifting, each phase of `sck` lasts `cfg_baud`+1 input clock cycles, so one bit time is 2×(`cfg_baud`+1) cycles.
- R2: When no word is in flight, `sck` equals `cfg_ckp` (0 gives idle low, 1 gives idle high). This includes gaps where the transmit FIFO is empty between words.
- R3: With `cfg_cke`=1, `sck` sits at the idle level for the first half of each bit time and at the opposite level for the second half. With `cfg_cke`=0 the two halves are swapped.
- R4: `mosi` carries the word most significant bit first. Each bit is held for one whole bit time and changes only at bit-time boundaries. `mosi` is 0 when idle.
- R5: `cfg_wsize` selects the word length: 0 selects 8 bits, 1 selects 16 bits, 2 selects 32 bits, and 3 is treated as 8 bits. Only the low bits of `tx_data` are sent.
- R6: With `cfg_smp`=0, `miso` is captured at the end of the first half of each bit time. With `cfg_smp`=1 it is captured at the end of the second half.
- R7: `rx_push` is high for exactly one cycle, right after the last bit of a word is captured. At that moment `rx_data` holds the received word right-aligned, with zeros above the word length.
- R8: `tx_pop` is asserted when the engine is idle and data is available. It is also asserted in the last cycle of a word when more data waits, so consecutive words follow with no idle cycle. It is never asserted while `tx_empty` is high.
- R9: `ss_n` is low only while `cfg_hw_ss`, `cfg_on` and `cfg_master` are all 1 and a word is either shifting or waiting. Otherwise it is high.
- R10: While `cfg_on` or `cfg_master` is 0, no word is popped. Clearing either one during a word ends that word on the next edge: `sck` returns to idle and nothing is pushed.
- R11: After reset, the engine is idle: `sck`=`cfg_ckp`, `ss_n`=1, and both `rx_push` and `tx_pop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_on | input | 1 | Module enable; clearing it aborts |
| cfg_master | input | 1 | Master mode enable |
| cfg_ckp | input | 1 | Idle level of `sck` |
| cfg_cke | input | 1 | 1: data changes on active-to-idle edge |
| cfg_smp | input | 1 | 1: sample at end of bit time |
| cfg_wsize | input | 2 | Word size code |
| cfg_baud | input | BAUD_W | Clock divider value N, sck = clk/(2(N+1)) |
| cfg_hw_ss | input | 1 | Enable hardware slave select |
| tx_empty | input | 1 | Transmit FIFO is empty |
| tx_data | input | 32 | Head word of transmit FIFO |
| tx_pop | output | 1 | Take the head word this cycle |
| rx_push | output | 1 | Received word valid strobe |
| rx_data | output | 32 | Received word, right-aligned |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The shift engine is exercised with several configurations:
- the two supported clock modes (idle-low with data launched on the active-to-idle edge, and idle-high with data launched on the idle-to-active edge);
- both of the remaining clock-level and edge pairings;
- all four word-size codes;
- divider values 0, 1, 2, 3 and 511.

Each configuration tells apart a different way of miscounting phases or bits. The slave device in the bench drives a different bit pattern in each half of every bit time, so a capture at the wrong point produces a different received word. Words are sent back to back, with an idle gap, and with an abort in the middle of a word. These cases separate the refill path, the idle clock level and the abort path. Separate runs with the hardware select disabled and with master mode cleared show that those controls gate `ss_n` and the pop.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int WORD_MAX = 32;
    localparam int CNT_W    = $clog2(WORD_MAX) + 1;

    typedef enum logic { ENG_IDLE, ENG_SHIFT } eng_state_e;
    typedef enum logic { HALF_LEAD, HALF_TRAIL } half_e;

    typedef struct packed {
        logic       ckp;
        logic       cke;
        logic       smp;
        logic [1:0] wsize;
    } spi_mode_t;

    function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] code);
        case (code)
            2'd1:    return CNT_W'(16);
            2'd2:    return CNT_W'(32);
            default: return CNT_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
    parameter int BAUD_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [BAUD_W-1:0] baud,
    output logic              tick
);
    logic [BAUD_W-1:0] cnt;

    assign tick = run && (cnt == baud);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_eng_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  spi_mode_t           mode,
    input  logic                tick,
    input  logic                tx_empty,
    input  logic [WORD_MAX-1:0] tx_data,
    input  logic                miso,
    output logic                tx_pop,
    output logic                busy,
    output logic                sck,
    output logic                mosi,
    output logic                rx_push,
    output logic [WORD_MAX-1:0] rx_data
);
    eng_state_e          state;
    half_e               half;
    logic [CNT_W-1:0]    bit_idx;
    logic [CNT_W-1:0]    nbits;
    logic [CNT_W-1:0]    align;
    logic [WORD_MAX-1:0] tx_sh;
    logic [WORD_MAX-1:0] rx_sh;
    logic [WORD_MAX-1:0] rx_next;
    logic                last_bit;
    logic                word_end;
    logic                sample;
    logic                can_load;
    logic                active_half;

    assign busy     = (state == ENG_SHIFT);
    assign nbits    = word_bits(mode.wsize);
    assign align    = CNT_W'(WORD_MAX) - nbits;
    assign last_bit = (bit_idx == nbits - CNT_W'(1));
    assign word_end = busy && tick && (half == HALF_TRAIL) && last_bit;
    assign can_load = en && !tx_empty && (!busy || word_end);
    assign sample   = busy && tick && (half == (mode.smp ? HALF_TRAIL : HALF_LEAD));
    assign rx_next  = {rx_sh[WORD_MAX-2:0], miso};
    assign tx_pop   = can_load;

    // Leading half is idle level when launching on the active-to-idle edge.
    assign active_half = mode.cke ? (half == HALF_TRAIL) : (half == HALF_LEAD);
    assign sck  = busy ? (mode.ckp ^ active_half) : mode.ckp;
    assign mosi = busy & tx_sh[WORD_MAX-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ENG_IDLE;
            half    <= HALF_LEAD;
            bit_idx <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_push <= 1'b0;
            rx_data <= '0;
        end else if (!en) begin
            state   <= ENG_IDLE;
            half    <= HALF_LEAD;
            rx_push <= 1'b0;
        end else begin
            rx_push <= 1'b0;
            if (sample) begin
                rx_sh <= rx_next;
                if (last_bit) begin
                    rx_push <= 1'b1;
                    rx_data <= rx_next;
                end
            end
            if (can_load) begin
                state   <= ENG_SHIFT;
                half    <= HALF_LEAD;
                bit_idx <= '0;
                tx_sh   <= tx_data << align;
                rx_sh   <= '0;
            end else if (busy && tick) begin
                if (half == HALF_LEAD) begin
                    half <= HALF_TRAIL;
                end else if (last_bit) begin
                    state <= ENG_IDLE;
                    half  <= HALF_LEAD;
                end else begin
                    half    <= HALF_LEAD;
                    bit_idx <= bit_idx + 1'b1;
                    tx_sh   <= {tx_sh[WORD_MAX-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/spi_sel_ctl.sv
module spi_sel_ctl (
    input  logic en,
    input  logic hw_ss,
    input  logic busy,
    input  logic tx_empty,
    output logic ss_n
);
    assign ss_n = !(hw_ss && en && (busy || !tx_empty));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int BAUD_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_on,
    input  logic              cfg_master,
    input  logic              cfg_ckp,
    input  logic              cfg_cke,
    input  logic              cfg_smp,
    input  logic [1:0]        cfg_wsize,
    input  logic [BAUD_W-1:0] cfg_baud,
    input  logic              cfg_hw_ss,
    input  logic              tx_empty,
    input  logic [31:0]       tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [31:0]       rx_data,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);
    logic      en;
    logic      busy_w;
    logic      tick_w;
    spi_mode_t mode;

    assign en   = cfg_on && cfg_master;
    assign mode = '{ckp: cfg_ckp, cke: cfg_cke, smp: cfg_smp, wsize: cfg_wsize};

    spi_baud_gen #(.BAUD_W(BAUD_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (busy_w),
        .baud (cfg_baud),
        .tick (tick_w)
    );

    spi_shift_core u_core (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .mode     (mode),
        .tick     (tick_w),
        .tx_empty (tx_empty),
        .tx_data  (tx_data),
        .miso     (miso),
        .tx_pop   (tx_pop),
        .busy     (busy_w),
        .sck      (sck),
        .mosi     (mosi),
        .rx_push  (rx_push),
        .rx_data  (rx_data)
    );

    spi_sel_ctl u_sel (
        .en       (en),
        .hw_ss    (cfg_hw_ss),
        .busy     (busy_w),
        .tx_empty (tx_empty),
        .ss_n     (ss_n)
    );
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_on,
    input logic        cfg_master,
    input logic        cfg_ckp,
    input logic        cfg_hw_ss,
    input logic [1:0]  cfg_wsize,
    input logic        busy,
    input logic        tick,
    input logic        sck,
    input logic        ss_n,
    input logic        tx_pop,
    input logic        tx_empty,
    input logic        rx_push,
    input logic [31:0] rx_data
);
    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck == cfg_ckp)); // R2

    AST_SCK_HOLD_PHASE: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(tick)) |-> $stable(sck)); // R1

    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> !tx_empty); // R8

    AST_SS_GATED: assert property (@(posedge clk) disable iff (rst)
        (!cfg_hw_ss || !cfg_on || !cfg_master) |-> ss_n); // R9

    AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_push |=> !rx_push); // R7

    AST_RX_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (rx_push && cfg_wsize == 2'd0) |-> (rx_data[31:8] == 24'd0)); // R7

    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst)
        (!cfg_on || !cfg_master) |=> !busy); // R10

    AST_NO_POP_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!cfg_on || !cfg_master) |-> !tx_pop); // R10
endmodule

bind spi_shift_engine spi_shift_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_on     (cfg_on),
    .cfg_master (cfg_master),
    .cfg_ckp    (cfg_ckp),
    .cfg_hw_ss  (cfg_hw_ss),
    .cfg_wsize  (cfg_wsize),
    .busy       (busy_w),
    .tick       (tick_w),
    .sck        (sck),
    .ss_n       (ss_n),
    .tx_pop     (tx_pop),
    .tx_empty   (tx_empty),
    .rx_push    (rx_push),
    .rx_data    (rx_data)
);

// File: tb/sim_spi_shift_engine.sv
module sim_spi_shift_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_on = 1'b0, cfg_master = 1'b0, cfg_ckp = 1'b0, cfg_cke = 1'b1;
    logic        cfg_smp = 1'b1, cfg_hw_ss = 1'b1;
    logic [1:0]  cfg_wsize = 2'd0;
    logic [8:0]  cfg_baud = 9'd0;
    logic        tx_empty = 1'b1;
    logic [31:0] tx_data = '0;
    logic        miso = 1'b0;
    logic        tx_pop, rx_push, sck, mosi, ss_n;
    logic [31:0] rx_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    int          q[$];
    bit          mbusy = 1'b0;
    int          mpos, mw, mhp;
    logic [31:0] mword, mpat_a, mpat_b, mexp_rx;
    bit          exp_push = 1'b0;
    logic [31:0] exp_rxd;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_shift_engine u0 (
        .clk(clk), .rst(rst), .cfg_on(cfg_on), .cfg_master(cfg_master),
        .cfg_ckp(cfg_ckp), .cfg_cke(cfg_cke), .cfg_smp(cfg_smp),
        .cfg_wsize(cfg_wsize), .cfg_baud(cfg_baud), .cfg_hw_ss(cfg_hw_ss),
        .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_data), .sck(sck), .mosi(mosi),
        .miso(miso), .ss_n(ss_n)
    );

    function automatic int size_of(input logic [1:0] c);
        if (c == 2'd2) return 32;
        if (c == 2'd1) return 16;
        return 8;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic load_word();
        logic [63:0] mask;
        mword  = q.pop_front();
        mw     = size_of(cfg_wsize);
        mhp    = int'(cfg_baud) + 1;
        mpos   = 0;
        mbusy  = 1'b1;
        mpat_a = {mword[15:0], mword[31:16]} ^ 32'h3C96_A50F;
        mpat_b = ~mpat_a;
        mask   = (64'd1 << mw) - 64'd1;
        mexp_rx = (cfg_smp ? mpat_b : mpat_a) & mask[31:0];
    endtask

    task automatic model_edge();
        bit en;
        int last_a, last_b;
        en = cfg_on && cfg_master;
        exp_push = 1'b0;
        if (!en) begin
            mbusy = 1'b0;
        end else if (mbusy) begin
            last_a = (2*mw - 1)*mhp - 1;
            last_b = 2*mw*mhp - 1;
            if ((cfg_smp && mpos == last_b) || (!cfg_smp && mpos == last_a)) begin
                exp_push = 1'b1;
                exp_rxd  = mexp_rx;
            end
            if (mpos == last_b) begin
                if (q.size() > 0) load_word();
                else mbusy = 1'b0;
            end else begin
                mpos++;
            end
        end else if (q.size() > 0) begin
            load_word();
        end
    endtask

    task automatic drive();
        int b;
        tx_empty = (q.size() == 0);
        tx_data  = (q.size() > 0) ? q[0] : 32'd0;
        if (mbusy) begin
            b = mpos / (2*mhp);
            miso = ((mpos / mhp) % 2 == 1) ? mpat_b[mw-1-b] : mpat_a[mw-1-b];
        end else begin
            miso = 1'b0;
        end
    endtask

    task automatic compare();
        bit en, second, exp_sck, exp_pop, exp_ss;
        en = cfg_on && cfg_master;
        if (mbusy) begin
            second  = ((mpos / mhp) % 2 == 1);
            exp_sck = cfg_ckp ^ (cfg_cke ? second : !second);
            chk(32'(sck), 32'(exp_sck), "R1 R3 sck phase");
            chk(32'(mosi), 32'(mword[mw-1-(mpos/(2*mhp))]), "R4 R5 mosi bit");
        end else begin
            chk(32'(sck), 32'(cfg_ckp), "R2 sck idle");
        end
        chk(32'(rx_push), 32'(exp_push), "R6 R7 rx_push");
        if (exp_push) chk(rx_data, exp_rxd, "R6 R7 rx_data");
        exp_pop = en && (q.size() > 0) && (!mbusy || mpos == 2*mw*mhp - 1);
        chk(32'(tx_pop), 32'(exp_pop), "R8 R10 tx_pop");
        exp_ss = !(cfg_hw_ss && en && (mbusy || q.size() > 0));
        chk(32'(ss_n), 32'(exp_ss), "R9 ss_n");
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        drive();
        compare();
    endtask

    task automatic push(input logic [31:0] w);
        q.push_back(int'(w));
        drive();
    endtask

    task automatic run_idle();
        int guard = 0;
        while ((mbusy || q.size() > 0) && guard < 100000) begin
            step();
            guard++;
        end
        repeat (3) step();
    endtask

    task automatic set_mode(input bit ckp, input bit cke, input bit smp,
                            input logic [1:0] ws, input logic [8:0] bd);
        cfg_ckp = ckp; cfg_cke = cke; cfg_smp = smp; cfg_wsize = ws; cfg_baud = bd;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R8 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        repeat (3) @(posedge clk);
        #1;
        chk(32'(sck), 32'(cfg_ckp), "R11 reset sck");
        chk(32'(ss_n), 32'd1, "R11 reset ss_n");
        chk(32'(rx_push), 32'd0, "R11 reset rx_push");
        chk(32'(tx_pop), 32'd0, "R11 reset tx_pop");
        @(negedge clk);
        rst = 1'b0;
        cfg_on = 1'b1; cfg_master = 1'b1;
        step();

        // mode 0, 8-bit, fastest clock, late sample, back to back (R8)
        set_mode(1'b0, 1'b1, 1'b1, 2'd0, 9'd0);
        push(32'h0000_00A5); push(32'h0000_003C); push(32'h0000_FF01);
        run_idle();

        // mode 3, 16-bit, divider 2, middle sample
        set_mode(1'b1, 1'b0, 1'b0, 2'd1, 9'd2);
        step();
        push(32'h0000_8001); push(32'hFFFF_1234);
        run_idle();

        // idle-low / early launch, 32-bit, divider 1
        set_mode(1'b0, 1'b0, 1'b1, 2'd2, 9'd1);
        step();
        push(32'hDEAD_BEEF); push(32'h0000_0001);
        run_idle();

        // reserved size code behaves as 8 bits (R5)
        set_mode(1'b1, 1'b1, 1'b0, 2'd3, 9'd3);
        step();
        push(32'h0000_015A);
        run_idle();

        // gap with empty FIFO keeps sck idle (R2)
        set_mode(1'b0, 1'b1, 1'b1, 2'd0, 9'd0);
        step();
        push(32'h81);
        run_idle();
        repeat (5) step();
        push(32'h7E);
        run_idle();

        // hardware select disabled (R9)
        cfg_hw_ss = 1'b0;
        push(32'hC3);
        run_idle();
        cfg_hw_ss = 1'b1;

        // master mode cleared: nothing popped (R10)
        cfg_master = 1'b0;
        push(32'h5A);
        repeat (10) step();
        chk(32'(q.size()), 32'd1, "R10 word left queued");
        cfg_master = 1'b1;
        run_idle();

        // abort mid-word (R10)
        set_mode(1'b0, 1'b1, 1'b1, 2'd1, 9'd1);
        step();
        push(32'hA55A); push(32'h1111);
        repeat (20) step();
        cfg_on = 1'b0;
        repeat (5) step();
        chk(32'(sck), 32'(cfg_ckp), "R10 sck idle after abort");
        q.delete();
        drive();
        step();
        cfg_on = 1'b1;
        step();

        // largest divider (R1)
        set_mode(1'b0, 1'b1, 1'b0, 2'd0, 9'd511);
        step();
        push(32'h96);
        run_idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule